// File: doc/BRIEF.md
# Coherent 16-bit Register Buffer

This block holds a bank of 16-bit timer registers, one period limit and a set of channel match values, that software updates one byte at a time over an 8-bit bus. Byte writes never reach the live value directly: each register has a staging buffer with a separate marker per byte. The live value takes the staged word only after both bytes have been staged. For a register whose pulse-width mode flag is set, it also waits for the period-boundary strobe from the counter.

Each register has its own control-write strobe. A control write throws away any half-finished update for that register. The timer logic always reads the live values. Decoding of the register map is left to the surrounding logic, so the strobes arrive already split per register and per byte lane.

Top module: `cbuf_bank`

## Requirements
- R1: While reset is low and on leaving it, every live value in `live_val` reads 0x0000.
- R2: A write of only one byte lane leaves that register's live value unchanged.
- R3: With the mode flag low, the live value loads at the clock edge on which the second of the two byte lanes is written. Lane `wr_hi` carries bits 15:8 and lane `wr_lo` carries bits 7:0. When both lanes are strobed in one cycle, both take `wr_byte`.
- R4: The two bytes may be staged in either order, and the result is the same.
- R5: A lane written more than once before the transfer keeps its latest byte.
- R6: With the mode flag high, a complete pair loads only at an edge where `period_edge` is high. The pair counts as complete if its last byte arrives in that same cycle.
- R7: A transfer clears both byte markers, so a later boundary with only one fresh byte leaves the live value unchanged.
- R8: A control write clears both byte markers and blocks any transfer in that cycle. A byte staged before the cancel must be written again before a transfer can happen.
- R9: A byte write in the same cycle as a control write to that register is discarded.
- R10: Registers are independent. Writes, cancels and transfers on one register leave the others unchanged.
- R11: If the mode flag drops while a complete pair is waiting, the pair loads at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_hi | input | NREG | Per-register strobe for the upper byte lane |
| wr_lo | input | NREG | Per-register strobe for the lower byte lane |
| wr_byte | input | 8 | Data byte for any lane write |
| ctrl_wr | input | NREG | Per-register control-write strobe (cancel) |
| pwm_mode | input | NREG | Per-register flag: hold transfers until the period boundary |
| period_edge | input | 1 | Counter reached its limit and reverses |
| live_val | output | 16*NREG | Live values, register i in bits 16i+15:16i |

## Verification
The bench targets several corner cases, each of which would go wrong in a visible way in a faulty design:
- **Byte order.** If the pair were loaded with the lanes swapped, or only accepted in one order, the low-first case would show the wrong word.
- **Repeated lane writes.** A design that kept the first byte instead of the last would show the stale byte.
- **Boundary waiting.** A design that ignored the boundary in pulse-width mode would load too early. One that did not clear markers after a transfer would load again on the next boundary with only one fresh byte.
- **Cancels.** A design that let a byte through in the same cycle as a cancel, or that kept the old marker after a cancel, would load a word the bench expects to be held back. Crosstalk between registers would show up as changes on registers that were not touched.

// File: rtl/cbuf_pkg.sv
// Shared types for the coherent register buffer.
// Assumes an 8-bit bus and 16-bit timer registers made of two byte lanes.
package cbuf_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // Markers recording which lanes hold fresh staged data
    typedef struct packed {
        logic hi_seen;
        logic lo_seen;
    } seen_t;
endpackage

// File: rtl/cbuf_shadow.sv
// Staging buffer for one 16-bit register.
// Keeps both staged bytes and a marker per lane. It presents the word as it
// stands including this cycle's write, and flags when both lanes are staged.
// Assumes cancel and take are single-cycle strobes. Cancel discards the
// incoming byte and has priority.
module cbuf_shadow
    import cbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_hi,
    input  logic  wr_lo,
    input  byte_t wr_byte,
    input  logic  cancel,
    input  logic  take,
    output word_t staged_word,
    output logic  pair_ready
);
    byte_t hi_q, lo_q, hi_n, lo_n;
    seen_t seen_q, seen_n;

    // Merge this cycle's lane writes into the staged bytes and markers
    always_comb begin
        hi_n           = wr_hi ? wr_byte : hi_q;
        lo_n           = wr_lo ? wr_byte : lo_q;
        seen_n.hi_seen = seen_q.hi_seen | wr_hi;
        seen_n.lo_seen = seen_q.lo_seen | wr_lo;
    end

    assign staged_word = {hi_n, lo_n};
    assign pair_ready  = seen_n.hi_seen & seen_n.lo_seen;

    // Update the staging registers; a cancel or a transfer clears the markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            seen_q <= '0;
        end else if (cancel) begin
            seen_q <= '0;
        end else if (take) begin
            hi_q   <= hi_n;
            lo_q   <= lo_n;
            seen_q <= '0;
        end else begin
            hi_q   <= hi_n;
            lo_q   <= lo_n;
            seen_q <= seen_n;
        end
    end
endmodule

// File: rtl/cbuf_commit.sv
// Transfer gate and live register for one 16-bit register.
// Loads the staged word when the pair is complete, no cancel is present, and
// either compare mode is in effect or the period boundary is signalled.
// Assumes period_edge is a single-cycle strobe.
module cbuf_commit
    import cbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pair_ready,
    input  word_t staged_word,
    input  logic  cancel,
    input  logic  pwm_mode,
    input  logic  period_edge,
    output logic  take,
    output word_t live_q
);
    // Decide whether this cycle transfers staged data
    always_comb begin
        take = pair_ready & ~cancel & (~pwm_mode | period_edge);
    end

    // Hold the live value, loading it on a transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (take) begin
            live_q <= staged_word;
        end
    end
endmodule

// File: rtl/cbuf_bank.sv
// Bank of coherent 16-bit timer registers written over an 8-bit bus.
// Slot 0 is intended for the period limit and the rest for channel values,
// but all slots behave alike. Register decoding is done outside.
// Assumes all strobes are already qualified per slot and last one cycle.
module cbuf_bank
    import cbuf_pkg::*;
#(
    parameter int NREG = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREG-1:0]       wr_hi,
    input  logic [NREG-1:0]       wr_lo,
    input  logic [BYTE_W-1:0]     wr_byte,
    input  logic [NREG-1:0]       ctrl_wr,
    input  logic [NREG-1:0]       pwm_mode,
    input  logic                  period_edge,
    output logic [NREG*WORD_W-1:0] live_val
);
    localparam int FLAT_W = NREG * WORD_W;

    for (genvar s = 0; s < NREG; s++) begin : g_slot
        word_t staged;
        word_t live;
        logic  ready;
        logic  take;

        cbuf_shadow u_shadow (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_hi      (wr_hi[s]),
            .wr_lo      (wr_lo[s]),
            .wr_byte    (wr_byte),
            .cancel     (ctrl_wr[s]),
            .take       (take),
            .staged_word(staged),
            .pair_ready (ready)
        );

        cbuf_commit u_commit (
            .clk        (clk),
            .rst_n      (rst_n),
            .pair_ready (ready),
            .staged_word(staged),
            .cancel     (ctrl_wr[s]),
            .pwm_mode   (pwm_mode[s]),
            .period_edge(period_edge),
            .take       (take),
            .live_q     (live)
        );

        assign live_val[s*WORD_W +: WORD_W] = live;
    end

    initial begin
        if (FLAT_W != NREG * 16) $error("cbuf_bank: word width must be 16");
    end
endmodule

// File: rtl/cbuf_bank_chk.sv
// Checker for cbuf_bank: per-slot protocol properties over the ports.
// Assumes the same strobe conventions as the bank.
module cbuf_bank_chk #(
    parameter int NREG = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREG-1:0]   wr_hi,
    input logic [NREG-1:0]   wr_lo,
    input logic [7:0]        wr_byte,
    input logic [NREG-1:0]   ctrl_wr,
    input logic [NREG-1:0]   pwm_mode,
    input logic              period_edge,
    input logic [NREG*16-1:0] live_val
);
    for (genvar s = 0; s < NREG; s++) begin : g_chk
        // R3
        both_lanes_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pwm_mode[s] && !ctrl_wr[s] && wr_hi[s] && wr_lo[s])
            |=> live_val[s*16 +: 16] == {$past(wr_byte), $past(wr_byte)});

        // R6
        pwm_waits_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwm_mode[s] && !period_edge) |=> $stable(live_val[s*16 +: 16]));

        // R8
        cancel_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_wr[s] |=> $stable(live_val[s*16 +: 16]));

        // R2
        idle_compare_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_hi[s] && !wr_lo[s] && !pwm_mode[s] && $past(!pwm_mode[s]))
            |=> $stable(live_val[s*16 +: 16]));
    end
endmodule

bind cbuf_bank cbuf_bank_chk #(.NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hi      (wr_hi),
    .wr_lo      (wr_lo),
    .wr_byte    (wr_byte),
    .ctrl_wr    (ctrl_wr),
    .pwm_mode   (pwm_mode),
    .period_edge(period_edge),
    .live_val   (live_val)
);

// File: tb/cbuf_bank_tb.sv
// Scoreboard bench: the driver pushes expected live values per cycle and a
// monitor compares them half a cycle after the edge that should produce them.
module cbuf_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 3;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [NREG-1:0]   wr_hi = 0, wr_lo = 0, ctrl_wr = 0, pwm_mode = 0;
    logic [7:0]        wr_byte = 0;
    logic              period_edge = 0;
    logic [NREG*16-1:0] live_val;

    logic [15:0]       exp_v [NREG];
    logic [NREG*16-1:0] q_exp[$];
    string             q_tag[$];
    int                n_chk = 0, n_bad = 0;
    bit                done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbuf_bank #(.NREG(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_byte(wr_byte), .ctrl_wr(ctrl_wr), .pwm_mode(pwm_mode),
        .period_edge(period_edge), .live_val(live_val)
    );

    function automatic logic [NREG*16-1:0] pack_exp();
        logic [NREG*16-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*16 +: 16] = exp_v[i];
        return f;
    endfunction

    // One clock: inputs are already set; queue the expectation, clear strobes
    task automatic cyc(string tag);
        @(posedge clk);
        #1;
        q_exp.push_back(pack_exp());
        q_tag.push_back(tag);
        @(negedge clk);
        wr_hi = 0; wr_lo = 0; ctrl_wr = 0; period_edge = 0;
    endtask

    task automatic wb(int slot, bit hi, logic [7:0] d);
        wr_byte = d;
        if (hi) wr_hi[slot] = 1'b1; else wr_lo[slot] = 1'b1;
    endtask

    // Monitor: compare the live outputs against the scoreboard
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [NREG*16-1:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_chk++;
            if (live_val !== e) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", t, live_val, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) exp_v[i] = 16'h0000;
        repeat (3) @(negedge clk);
        cyc("R1 in reset");
        rst_n = 1;
        cyc("R1 after reset");

        // Compare mode, high first
        wb(0, 1, 8'h12);                     cyc("R2 single high byte");
        wb(0, 0, 8'h34); exp_v[0] = 16'h1234; cyc("R3 pair completes");
        // Low first on slot 1
        wb(1, 0, 8'hCD);                     cyc("R2 single low byte");
        wb(1, 1, 8'hAB); exp_v[1] = 16'hABCD; cyc("R4 low then high");
        // Repeated lane
        wb(2, 1, 8'h11);                     cyc("R5 first high");
        wb(2, 1, 8'h22);                     cyc("R5 second high");
        wb(2, 0, 8'h33); exp_v[2] = 16'h2233; cyc("R5 latest kept");

        // Pulse-width mode on slot 0
        pwm_mode = 3'b001;
        wb(0, 1, 8'h56);                     cyc("R6 staged high");
        wb(0, 0, 8'h78);                     cyc("R6 pair waits");
        cyc("R6 idle waits");
        period_edge = 1; exp_v[0] = 16'h5678; cyc("R6 boundary loads");
        wb(0, 1, 8'h9A);                     cyc("R7 stage high");
        period_edge = 1;                     cyc("R7 boundary one byte");
        wb(0, 0, 8'hBC); period_edge = 1; exp_v[0] = 16'h9ABC; cyc("R6 same-cycle completion");

        // Cancel
        wb(0, 1, 8'h01);                     cyc("R8 stage");
        ctrl_wr[0] = 1;                      cyc("R8 cancel");
        wb(0, 0, 8'h02);                     cyc("R8 low after cancel");
        period_edge = 1;                     cyc("R8 stale high gone");
        wb(0, 1, 8'h03); period_edge = 1; exp_v[0] = 16'h0302; cyc("R8 refill loads");

        // Cancel same cycle as byte write
        wb(1, 1, 8'h44); ctrl_wr[1] = 1;     cyc("R9 write with cancel");
        wb(1, 0, 8'h55);                     cyc("R9 high discarded");
        wb(1, 1, 8'h66); exp_v[1] = 16'h6655; cyc("R9 rewrite loads");

        // Mode drop releases a waiting pair
        pwm_mode = 3'b101;
        wb(2, 1, 8'h77);                     cyc("R11 stage high");
        wb(2, 0, 8'h88);                     cyc("R11 pair waits");
        pwm_mode = 3'b001; exp_v[2] = 16'h7788; cyc("R11 mode drop loads");

        // Independence and both lanes at once
        wb(2, 1, 8'h99); ctrl_wr[1] = 1;     cyc("R10 other cancel");
        wb(2, 0, 8'hAA); exp_v[2] = 16'h99AA; cyc("R10 slot2 unaffected");
        pwm_mode = 3'b000;
        wr_byte = 8'h5A; wr_hi[1] = 1; wr_lo[1] = 1; exp_v[1] = 16'h5A5A; cyc("R3 both lanes");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule